// File: doc/BRIEF.md
# Bit-Serial FPGA Configuration Loader

This block is the host side of a serial configuration link to an FPGA. After a one-cycle start strobe it drives the device's active-low program pin low and waits for the device's active-low init pin to go low. It then releases the program pin and waits for the init pin to go high again. Next it takes configuration bytes from a valid/ready stream and sends each one out most significant bit first on a data pin, with one configuration clock edge per bit. Once the byte marked last has gone out, it holds the data pin high and keeps toggling the configuration clock until the device raises its done pin.

Every wait has a cycle limit. An init pin that goes low while done is still low is taken as a checksum failure reported by the device. The controller ends every run with a one-cycle result pulse and a three-bit result code. The length of each half of the configuration clock is a parameter, counted in system clocks, and so is the limit on each wait.

Top module: `serial_cfg_loader`

## Requirements
- R1: When reset is released, cfgProgN is high, cfgClk is low, cfgData is high, and busy, byteReady and resultValid are all low.
- R2: After startPulse, cfgProgN is driven low and stays low until cfgInitN is seen low. If cfgInitN does not go low within TIMEOUT_CYCLES clocks, the run ends with result code 1. cfgProgN is never low while the block is idle.
- R3: After cfgInitN goes low, cfgProgN is released and the block waits for cfgInitN to return high. If it does not return high within TIMEOUT_CYCLES clocks, the run ends with result code 2.
- R4: Each byte goes out most significant bit first, one bit per rising edge of cfgClk. Each high phase of cfgClk lasts exactly HALF_CYCLES clocks, and cfgData changes only while cfgClk is low.
- R5: A byte is accepted only on a clock where byteValid and byteReady are both high. The next byte is requested only after bit 0 of the current byte has been clocked out. byteReady is never high while busy is low.
- R6: Before each byte is fetched, if cfgInitN is low and cfgDone is low, the run ends with result code 3 and no further byte is accepted.
- R7: After the byte flagged by byteLast, cfgData stays high and cfgClk keeps toggling until cfgDone is seen high. The run then ends with result code 0.
- R8: If cfgDone does not go high within TIMEOUT_CYCLES clocks of the end of the last byte, the run ends with result code 4.
- R9: Every run ends with a resultValid pulse that lasts exactly one clock. On that clock busy is low, and resultCode holds one of the values 0 to 4 and keeps it until the next run ends.
- R10: A startPulse that arrives while busy is high is ignored. The run in progress continues unchanged and produces exactly one result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | One-cycle request to begin a configuration run |
| byteData | input | BYTE_W | Configuration byte offered on the stream |
| byteValid | input | 1 | byteData holds a byte |
| byteLast | input | 1 | The offered byte is the final one of the bitstream |
| byteReady | output | 1 | The loader takes the offered byte on this clock |
| cfgInitN | input | 1 | Device init pin, active low |
| cfgDone | input | 1 | Device done pin, active high |
| cfgProgN | output | 1 | Device program pin, active low |
| cfgClk | output | 1 | Configuration clock to the device |
| cfgData | output | 1 | Serial configuration data to the device |
| busy | output | 1 | A run is in progress |
| resultValid | output | 1 | One-cycle pulse at the end of a run |
| resultCode | output | 3 | 0 ok, 1 init-entry timeout, 2 init-exit timeout, 3 checksum error, 4 done timeout |

## Verification
The assertions check only the block's own outputs. They therefore assume nothing about the waveform on cfgInitN or cfgDone, and they hold even when the device model stalls, drops init in the middle of a stream, or never raises done. They do assume that the byte stream follows valid/ready rules: a byte stays offered and unchanged until it is taken, and byteLast is set on the final byte only. The bench's feeder changes byteData only on the falling clock edge after a handshake, and marks only the final byte as last. It also drives startPulse as a single-cycle strobe.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_INITWAIT,
    ST_FETCH,
    ST_SHLO,
    ST_SHHI,
    ST_FLLO,
    ST_FLHI
  } ldr_state_e;

  typedef enum logic [2:0] {
    RES_OK            = 3'd0,
    RES_INIT_START_TO = 3'd1,
    RES_INIT_CLEAR_TO = 3'd2,
    RES_CRC           = 3'd3,
    RES_DONE_TO       = 3'd4
  } ldr_result_e;

  // strobes from control to datapath
  typedef struct packed {
    logic progLow;
    logic clkHigh;
    logic dinHigh;
    logic loadByte;
    logic shiftBit;
    logic phaseClr;
    logic toClr;
  } ldr_ctl_t;

  // status from datapath to control
  typedef struct packed {
    logic phaseDone;
    logic bitZero;
    logic lastFlag;
    logic toExpired;
  } ldr_sts_t;

endpackage

// File: rtl/cfg_loader_dp.sv
module cfg_loader_dp
  import cfg_loader_pkg::*;
#(
  parameter int BYTE_W         = 8,
  parameter int HALF_CYCLES    = 4,
  parameter int TIMEOUT_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ldr_ctl_t          ctl,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              byteLast,
  output ldr_sts_t          sts,
  output logic              cfgProgN,
  output logic              cfgClk,
  output logic              cfgData
);
  localparam int BIT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam int PH_W  = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam int TO_W  = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(BYTE_W - 1);
  localparam logic [PH_W-1:0]  PH_END  = PH_W'(HALF_CYCLES - 1);
  localparam logic [TO_W-1:0]  TO_END  = TO_W'(TIMEOUT_CYCLES - 1);

  logic [BYTE_W-1:0] shiftReg;
  logic [BIT_W-1:0]  bitCnt;
  logic              lastReg;
  logic [PH_W-1:0]   phaseCnt;
  logic [TO_W-1:0]   toCnt;

  assign sts.phaseDone = (phaseCnt == PH_END);
  assign sts.bitZero   = (bitCnt == '0);
  assign sts.lastFlag  = lastReg;
  assign sts.toExpired = (toCnt == TO_END);

  // byte shifter and bit position
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      lastReg  <= 1'b0;
    end else if (ctl.loadByte) begin
      shiftReg <= byteData;
      bitCnt   <= BIT_TOP;
      lastReg  <= byteLast;
    end else if (ctl.shiftBit) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
      bitCnt   <= bitCnt - 1'b1;
    end
  end

  // half-period counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                phaseCnt <= '0;
    else if (ctl.phaseClr)    phaseCnt <= '0;
    else if (!sts.phaseDone)  phaseCnt <= phaseCnt + 1'b1;
  end

  // wait-limit counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                toCnt <= '0;
    else if (ctl.toClr)       toCnt <= '0;
    else if (!sts.toExpired)  toCnt <= toCnt + 1'b1;
  end

  // registered pin drivers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgProgN <= 1'b1;
      cfgClk   <= 1'b0;
      cfgData  <= 1'b1;
    end else begin
      cfgProgN <= !ctl.progLow;
      cfgClk   <= ctl.clkHigh;
      cfgData  <= ctl.dinHigh ? 1'b1 : shiftReg[BYTE_W-1];
    end
  end
endmodule

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startPulse,
  input  logic     byteValid,
  input  logic     cfgInitN,
  input  logic     cfgDone,
  input  ldr_sts_t sts,
  output ldr_ctl_t ctl,
  output logic     byteReady,
  output logic     busy,
  output logic     resultValid,
  output logic [2:0] resultCode
);
  ldr_state_e  state, nextState;
  ldr_result_e finCode, codeReg;
  logic        finish;
  logic        crcSeen;

  assign crcSeen = !cfgDone && !cfgInitN;
  assign busy    = (state != ST_IDLE);

  always_comb begin
    ctl       = '0;
    nextState = state;
    finish    = 1'b0;
    finCode   = RES_OK;
    byteReady = 1'b0;
    unique case (state)
      ST_IDLE: begin
        ctl.dinHigh = 1'b1;
        if (startPulse) begin
          ctl.toClr = 1'b1;
          nextState = ST_PROG;
        end
      end
      ST_PROG: begin
        ctl.progLow = 1'b1;
        ctl.dinHigh = 1'b1;
        if (!cfgInitN) begin
          ctl.toClr = 1'b1;
          nextState = ST_INITWAIT;
        end else if (sts.toExpired) begin
          finish    = 1'b1;
          finCode   = RES_INIT_START_TO;
          nextState = ST_IDLE;
        end
      end
      ST_INITWAIT: begin
        ctl.dinHigh = 1'b1;
        if (cfgInitN) begin
          nextState = ST_FETCH;
        end else if (sts.toExpired) begin
          finish    = 1'b1;
          finCode   = RES_INIT_CLEAR_TO;
          nextState = ST_IDLE;
        end
      end
      ST_FETCH: begin
        if (crcSeen) begin
          finish    = 1'b1;
          finCode   = RES_CRC;
          nextState = ST_IDLE;
        end else begin
          byteReady = 1'b1;
          if (byteValid) begin
            ctl.loadByte = 1'b1;
            ctl.phaseClr = 1'b1;
            nextState    = ST_SHLO;
          end
        end
      end
      ST_SHLO: begin
        if (sts.phaseDone) begin
          ctl.phaseClr = 1'b1;
          nextState    = ST_SHHI;
        end
      end
      ST_SHHI: begin
        ctl.clkHigh = 1'b1;
        if (sts.phaseDone) begin
          ctl.phaseClr = 1'b1;
          if (!sts.bitZero) begin
            ctl.shiftBit = 1'b1;
            nextState    = ST_SHLO;
          end else if (sts.lastFlag) begin
            ctl.toClr = 1'b1;
            nextState = ST_FLLO;
          end else begin
            nextState = ST_FETCH;
          end
        end
      end
      ST_FLLO, ST_FLHI: begin
        ctl.dinHigh = 1'b1;
        ctl.clkHigh = (state == ST_FLHI);
        if (cfgDone) begin
          finish    = 1'b1;
          finCode   = RES_OK;
          nextState = ST_IDLE;
        end else if (sts.toExpired) begin
          finish    = 1'b1;
          finCode   = RES_DONE_TO;
          nextState = ST_IDLE;
        end else if (sts.phaseDone) begin
          ctl.phaseClr = 1'b1;
          nextState    = (state == ST_FLLO) ? ST_FLHI : ST_FLLO;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      resultValid <= 1'b0;
      codeReg     <= RES_OK;
    end else begin
      state       <= nextState;
      resultValid <= finish;
      if (finish) codeReg <= finCode;
    end
  end

  assign resultCode = codeReg;
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int BYTE_W         = 8,
  parameter int HALF_CYCLES    = 4,
  parameter int TIMEOUT_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              byteValid,
  input  logic              byteLast,
  output logic              byteReady,
  input  logic              cfgInitN,
  input  logic              cfgDone,
  output logic              cfgProgN,
  output logic              cfgClk,
  output logic              cfgData,
  output logic              busy,
  output logic              resultValid,
  output logic [2:0]        resultCode
);
  ldr_ctl_t ctl;
  ldr_sts_t sts;

  cfg_loader_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .byteValid   (byteValid),
    .cfgInitN    (cfgInitN),
    .cfgDone     (cfgDone),
    .sts         (sts),
    .ctl         (ctl),
    .byteReady   (byteReady),
    .busy        (busy),
    .resultValid (resultValid),
    .resultCode  (resultCode)
  );

  cfg_loader_dp #(
    .BYTE_W         (BYTE_W),
    .HALF_CYCLES    (HALF_CYCLES),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .byteData (byteData),
    .byteLast (byteLast),
    .sts      (sts),
    .cfgProgN (cfgProgN),
    .cfgClk   (cfgClk),
    .cfgData  (cfgData)
  );
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       byteReady,
  input logic       cfgProgN,
  input logic       cfgClk,
  input logic       cfgData,
  input logic       resultValid,
  input logic [2:0] resultCode
);
  AST_PROG_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> cfgProgN); // R2

  AST_DATA_HELD_CLK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (cfgClk && $past(cfgClk)) |-> $stable(cfgData)); // R4

  AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |-> busy); // R5

  AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid); // R9

  AST_RESULT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> !busy); // R9

  AST_RESULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (resultCode <= 3'd4)); // R9

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |=> (resultValid || $stable(resultCode))); // R9
endmodule

bind serial_cfg_loader serial_cfg_loader_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busy        (busy),
  .byteReady   (byteReady),
  .cfgProgN    (cfgProgN),
  .cfgClk      (cfgClk),
  .cfgData     (cfgData),
  .resultValid (resultValid),
  .resultCode  (resultCode)
);

// File: tb/tb_serial_cfg_loader.sv
module tb_serial_cfg_loader;
  localparam int HALF = 3;
  localparam int TMO  = 300;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic       byteValid = 1'b0;
  logic       byteLast = 1'b0;
  logic       byteReady;
  logic       cfgInitN = 1'b1;
  logic       cfgDone = 1'b0;
  logic       cfgProgN, cfgClk, cfgData, busy, resultValid;
  logic [2:0] resultCode;

  serial_cfg_loader #(.BYTE_W(8), .HALF_CYCLES(HALF), .TIMEOUT_CYCLES(TMO)) dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .byteData(byteData),
    .byteValid(byteValid), .byteLast(byteLast), .byteReady(byteReady),
    .cfgInitN(cfgInitN), .cfgDone(cfgDone), .cfgProgN(cfgProgN), .cfgClk(cfgClk),
    .cfgData(cfgData), .busy(busy), .resultValid(resultValid), .resultCode(resultCode)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // scenario knobs, written only by the stimulus tasks
  bit   modelClear = 1;
  bit   respondLow = 1, respondHigh = 1;
  int   doneAfter = -1, crcAt = -1, nBytes = 0;
  logic [7:0] feedBytes [0:7];

  // device model state
  bit   armed, prevClk, flushLow, crcHit, widthBad;
  int   bitsSeen, extraClks, hiRun;
  logic [63:0] capBits;

  always @(negedge clk) begin
    if (modelClear) begin
      cfgInitN <= 1'b1; cfgDone <= 1'b0; armed <= 0; prevClk <= 0;
      bitsSeen <= 0; extraClks <= 0; capBits <= '0; flushLow <= 0;
      crcHit <= 0; hiRun <= 0; widthBad <= 0;
    end else begin
      prevClk <= cfgClk;
      hiRun   <= cfgClk ? hiRun + 1 : 0;
      if (!cfgClk && prevClk && hiRun != HALF) widthBad <= 1;
      if (cfgClk && !prevClk) begin
        if (bitsSeen < nBytes * 8) begin
          capBits  <= {capBits[62:0], cfgData};
          bitsSeen <= bitsSeen + 1;
        end else begin
          extraClks <= extraClks + 1;
          if (!cfgData) flushLow <= 1;
        end
      end
      if (crcAt > 0 && bitsSeen >= crcAt) crcHit <= 1;
      if (!cfgProgN) begin
        armed <= 1;
        if (respondLow) cfgInitN <= 1'b0;
      end else if (crcHit) cfgInitN <= 1'b0;
      else if (armed && respondHigh) cfgInitN <= 1'b1;
      cfgDone <= armed && (doneAfter >= 0) && (bitsSeen == nBytes * 8) && (extraClks >= doneAfter);
    end
  end

  // byte feeder: data changes only on the falling edge after a handshake
  int  idx, acceptCount;
  bit  pendingTake;
  always @(negedge clk) begin
    int nextIdx;
    if (modelClear) begin
      idx <= 0; acceptCount <= 0; pendingTake <= 0;
      byteValid <= 1'b0; byteLast <= 1'b0; byteData <= 8'h00;
    end else begin
      nextIdx = pendingTake ? idx + 1 : idx;
      if (pendingTake) acceptCount <= acceptCount + 1;
      idx         <= nextIdx;
      pendingTake <= byteValid && byteReady && !pendingTake;
      if (!pendingTake && byteValid && byteReady) begin
        // handshake pending at the coming edge: keep the byte in place
      end else begin
        byteValid <= (nextIdx < nBytes);
        byteData  <= (nextIdx < nBytes) ? feedBytes[nextIdx[2:0]] : 8'h00;
        byteLast  <= (nextIdx == nBytes - 1);
      end
    end
  end

  // result monitor
  int cycleCnt = 0, resCount, resCycle, startCycle;
  logic [2:0] lastCode;
  always @(negedge clk) begin
    cycleCnt <= cycleCnt + 1;
    if (modelClear) begin
      resCount <= 0; lastCode <= 3'd7; resCycle <= 0;
    end else if (resultValid) begin
      resCount <= resCount + 1; lastCode <= resultCode; resCycle <= cycleCnt;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic setup(input bit lo, input bit hi, input int dAfter, input int crc,
                       input int n, input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2);
    rstN = 1'b0; modelClear = 1;
    respondLow = lo; respondHigh = hi; doneAfter = dAfter; crcAt = crc; nBytes = n;
    feedBytes[0] = b0; feedBytes[1] = b1; feedBytes[2] = b2;
    for (int i = 3; i < 8; i++) feedBytes[i] = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1; modelClear = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulseStart();
    @(negedge clk);
    startPulse = 1'b1; startCycle = cycleCnt;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic waitResult(input int maxCycles);
    int n = 0;
    while (resCount == 0 && n < maxCycles) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    setup(1, 1, 4, -1, 0, 8'h00, 8'h00, 8'h00);
    check(cfgProgN == 1'b1, "R1", "progN idle", cfgProgN, 1);
    check(cfgClk == 1'b0, "R1", "cclk idle", cfgClk, 0);
    check(cfgData == 1'b1, "R1", "din idle", cfgData, 1);
    check(!busy && !byteReady && !resultValid, "R1", "busy/ready/valid",
          {busy, byteReady, resultValid}, 0);
  endtask

  task automatic t_good_load();
    setup(1, 1, 5, -1, 3, 8'hA5, 8'h3C, 8'hF0);
    pulseStart();
    waitResult(2000);
    check(lastCode == 3'd0, "R7", "result code", lastCode, 0);
    check(capBits[23:0] == 24'hA53CF0, "R4", "captured bits msb first", capBits[23:0], 24'hA53CF0);
    check(widthBad == 0, "R4", "cclk high width", widthBad, 0);
    check(acceptCount == 3, "R5", "bytes accepted", acceptCount, 3);
    check(flushLow == 0 && extraClks >= 5, "R7", "flush clocks with din high", extraClks, 5);
    check(resCount == 1 && !busy, "R9", "single result, idle", resCount, 1);
    check(cfgProgN == 1'b1, "R3", "program released after load", cfgProgN, 1);
  endtask

  task automatic t_start_ignored();
    setup(1, 1, 3, -1, 2, 8'h81, 8'h7E, 8'h00);
    pulseStart();
    repeat (30) @(negedge clk);
    pulseStart();
    waitResult(2000);
    repeat (20) @(negedge clk);
    check(resCount == 1, "R10", "results after extra start", resCount, 1);
    check(lastCode == 3'd0, "R10", "result code", lastCode, 0);
    check(capBits[15:0] == 16'h817E, "R10", "bits unchanged", capBits[15:0], 16'h817E);
    check(!busy, "R10", "idle after run", busy, 0);
  endtask

  task automatic t_init_start_to();
    setup(0, 1, 3, -1, 1, 8'h55, 8'h00, 8'h00);
    pulseStart();
    repeat (10) @(negedge clk);
    check(cfgProgN == 1'b0, "R2", "program held low while waiting", cfgProgN, 0);
    waitResult(2000);
    check(lastCode == 3'd1, "R2", "init-entry timeout code", lastCode, 1);
    check((resCycle - startCycle) >= TMO - 1 && (resCycle - startCycle) <= TMO + 3,
          "R2", "timeout latency", resCycle - startCycle, TMO);
    check(acceptCount == 0, "R2", "no bytes taken", acceptCount, 0);
  endtask

  task automatic t_init_clear_to();
    setup(1, 0, 3, -1, 1, 8'h55, 8'h00, 8'h00);
    pulseStart();
    repeat (20) @(negedge clk);
    check(cfgProgN == 1'b1, "R3", "program released once init low", cfgProgN, 1);
    waitResult(2000);
    check(lastCode == 3'd2, "R3", "init-exit timeout code", lastCode, 2);
    check((resCycle - startCycle) >= TMO, "R3", "waited full limit", resCycle - startCycle, TMO);
    check(acceptCount == 0, "R3", "no bytes taken", acceptCount, 0);
  endtask

  task automatic t_crc();
    setup(1, 1, 3, 6, 3, 8'hC3, 8'h11, 8'h22);
    pulseStart();
    waitResult(2000);
    check(lastCode == 3'd3, "R6", "checksum error code", lastCode, 3);
    check(acceptCount == 1, "R6", "bytes taken before error", acceptCount, 1);
    check(!byteReady, "R6", "no request after error", byteReady, 0);
  endtask

  task automatic t_done_to();
    setup(1, 1, -1, -1, 1, 8'h9A, 8'h00, 8'h00);
    pulseStart();
    waitResult(3000);
    check(lastCode == 3'd4, "R8", "done timeout code", lastCode, 4);
    check(extraClks > 10 && flushLow == 0, "R8", "kept clocking with din high", extraClks, 11);
    check(capBits[7:0] == 8'h9A, "R8", "byte sent", capBits[7:0], 8'h9A);
  endtask

  initial begin
    t_reset();
    t_good_load();
    t_start_ignored();
    t_init_start_to();
    t_init_clear_to();
    t_crc();
    t_done_to();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule